// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of several DMA channels is handed to a single shared transfer engine. Each channel raises a request from one of two places: the status of its internal FIFO, or a request line from an external peripheral. For an internal requestor, the channel's configuration selects which FIFO status counts as the request: the "hungry" flag (the FIFO has room) or the "watermark" flag (the FIFO holds data). Each channel also has an enable bit and a 4-bit priority value. The smallest priority value wins.

The arbiter produces a registered one-hot grant, the matching channel index, and a valid flag. A grant stays in place until the engine reports that the transaction is finished with a single-cycle done pulse. At the clock edge that samples done, the arbiter picks a new winner from the requests present at that moment. The new grant therefore appears in the very next cycle, and no cycle is lost between two transactions. A grant is also released if its channel loses its enable.

Top module: `dma_ch_arbiter`

## Requirements
- R1: While rst_ni is low, grant_o is all zeros, grant_valid_o is 0 and grant_idx_o is 0.
- R2: The request seen for channel c depends on its select bits. If src_ext_i[c] is 1, the request is ext_req_i[c]. Otherwise, if wmark_sel_i[c] is 1, the request is fifo_wmark_i[c]. Otherwise the request is fifo_hungry_i[c].
- R3: A channel whose en_i bit is 0 at a clock edge is never granted in the cycle that follows that edge.
- R4: Among the eligible channels, the grant goes to the one with the smallest priority value. Channel c's priority is prio_i[c*4 +: 4], and 0 is the most urgent value.
- R5: When eligible channels share the smallest priority value, the channel with the lowest index is granted.
- R6: While a grant is held and done_i is 0, the grant does not change, whatever happens to requests or priorities.
- R7: At an edge where done_i is 1 during a held grant, the arbiter re-arbitrates. If any channel is eligible, a new grant is valid in the next cycle, with no idle cycle in between.
- R8: If no channel is eligible at a re-arbitration edge, grant_valid_o is 0 and grant_o is all zeros in the next cycle.
- R9: grant_o has at most one bit set. grant_valid_o equals the OR of grant_o. When grant_valid_o is 1, the set bit of grant_o is bit grant_idx_o.
- R10: If the enable of the held channel is 0 at an edge, the grant is released at that edge and arbitration is redone without that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | CH_N | Per-channel enable |
| src_ext_i | input | CH_N | 1: request comes from the external peripheral line; 0: request comes from FIFO status |
| wmark_sel_i | input | CH_N | For internal requestors, 1 selects the watermark flag and 0 selects the hungry flag |
| prio_i | input | CH_N*PRIO_W | Per-channel priority; channel c is at [c*PRIO_W +: PRIO_W]; 0 is the most urgent |
| fifo_hungry_i | input | CH_N | FIFO can accept more data |
| fifo_wmark_i | input | CH_N | FIFO holds data to drain |
| ext_req_i | input | CH_N | External peripheral request lines |
| done_i | input | 1 | Single-cycle pulse from the engine when the granted transaction is finished |
| grant_o | output | CH_N | One-hot grant |
| grant_idx_o | output | IDX_W | Index of the granted channel |
| grant_valid_o | output | 1 | A grant is active |

## Verification
The bench builds the block with its default parameters: 16 channels and 4-bit priorities. At this size, a 16-way tie on one priority value and the full range of priority values 0 to 15 can both be reached. Random priorities are drawn from a narrow range so that ties between channels happen often, which stresses the lowest-index rule. Done pulses are random as well, so that holds, back-to-back handovers and releases caused by a dropped enable all appear many times.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned DEF_CH_N   = 16;
  localparam int unsigned DEF_PRIO_W = 4;
endpackage

// File: rtl/dma_arb_req_sel.sv
module dma_arb_req_sel #(
  parameter int unsigned CH_N = dma_arb_pkg::DEF_CH_N
) (
  input  logic [CH_N-1:0] en_i,
  input  logic [CH_N-1:0] src_ext_i,
  input  logic [CH_N-1:0] wmark_sel_i,
  input  logic [CH_N-1:0] fifo_hungry_i,
  input  logic [CH_N-1:0] fifo_wmark_i,
  input  logic [CH_N-1:0] ext_req_i,
  output logic [CH_N-1:0] elig_o
);
  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic int_req;
    assign int_req   = wmark_sel_i[c] ? fifo_wmark_i[c] : fifo_hungry_i[c];
    assign elig_o[c] = en_i[c] & (src_ext_i[c] ? ext_req_i[c] : int_req);
  end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int unsigned CH_N   = dma_arb_pkg::DEF_CH_N,
  parameter int unsigned PRIO_W = dma_arb_pkg::DEF_PRIO_W,
  localparam int unsigned IDX_W = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic [CH_N-1:0]        elig_i,
  input  logic [CH_N*PRIO_W-1:0] prio_i,
  output logic                   win_valid_o,
  output logic [IDX_W-1:0]       win_idx_o
);
  logic [PRIO_W-1:0] best_prio;

  // linear scan from channel 0; strict compare keeps the lower index on ties
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    best_prio   = '1;
    for (int c = 0; c < CH_N; c++) begin
      if (elig_i[c] && (!win_valid_o || prio_i[c*PRIO_W +: PRIO_W] < best_prio)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(c);
        best_prio   = prio_i[c*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/dma_arb_grant_reg.sv
module dma_arb_grant_reg #(
  parameter int unsigned CH_N   = dma_arb_pkg::DEF_CH_N,
  localparam int unsigned IDX_W = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CH_N-1:0]  en_i,
  input  logic             done_i,
  input  logic             win_valid_i,
  input  logic [IDX_W-1:0] win_idx_i,
  output logic [CH_N-1:0]  grant_o,
  output logic [IDX_W-1:0] grant_idx_o,
  output logic             grant_valid_o
);
  logic             valid_q;
  logic [IDX_W-1:0] idx_q;
  logic             rearb;

  assign rearb = !valid_q || done_i || !en_i[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (rearb) begin
      valid_q <= win_valid_i;
      idx_q   <= win_valid_i ? win_idx_i : '0;
    end
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_dec
    assign grant_o[c] = valid_q && (idx_q == IDX_W'(c));
  end

  assign grant_idx_o   = idx_q;
  assign grant_valid_o = valid_q;
endmodule

// File: rtl/dma_ch_arbiter.sv
module dma_ch_arbiter #(
  parameter int unsigned CH_N   = dma_arb_pkg::DEF_CH_N,
  parameter int unsigned PRIO_W = dma_arb_pkg::DEF_PRIO_W,
  localparam int unsigned IDX_W = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CH_N-1:0]        en_i,
  input  logic [CH_N-1:0]        src_ext_i,
  input  logic [CH_N-1:0]        wmark_sel_i,
  input  logic [CH_N*PRIO_W-1:0] prio_i,
  input  logic [CH_N-1:0]        fifo_hungry_i,
  input  logic [CH_N-1:0]        fifo_wmark_i,
  input  logic [CH_N-1:0]        ext_req_i,
  input  logic                   done_i,
  output logic [CH_N-1:0]        grant_o,
  output logic [IDX_W-1:0]       grant_idx_o,
  output logic                   grant_valid_o
);
  logic [CH_N-1:0]  elig;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;

  dma_arb_req_sel #(.CH_N(CH_N)) u_sel (
    .en_i          (en_i),
    .src_ext_i     (src_ext_i),
    .wmark_sel_i   (wmark_sel_i),
    .fifo_hungry_i (fifo_hungry_i),
    .fifo_wmark_i  (fifo_wmark_i),
    .ext_req_i     (ext_req_i),
    .elig_o        (elig)
  );

  dma_arb_pick #(.CH_N(CH_N), .PRIO_W(PRIO_W)) u_pick (
    .elig_i      (elig),
    .prio_i      (prio_i),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx)
  );

  dma_arb_grant_reg #(.CH_N(CH_N)) u_greg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .done_i        (done_i),
    .win_valid_i   (win_valid),
    .win_idx_i     (win_idx),
    .grant_o       (grant_o),
    .grant_idx_o   (grant_idx_o),
    .grant_valid_o (grant_valid_o)
  );
endmodule

// File: rtl/dma_ch_arbiter_chk.sv
module dma_ch_arbiter_chk #(
  parameter int unsigned CH_N   = dma_arb_pkg::DEF_CH_N,
  localparam int unsigned IDX_W = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CH_N-1:0]  en_i,
  input logic             done_i,
  input logic [CH_N-1:0]  elig,
  input logic [CH_N-1:0]  grant_o,
  input logic [IDX_W-1:0] grant_idx_o,
  input logic             grant_valid_o
);
  // R9
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && (grant_valid_o == (grant_o != '0)));

  // R9
  grant_idx_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> grant_o[grant_idx_o]);

  // R3
  no_disabled_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~$past(en_i)) == '0);

  // R6
  grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && !done_i && en_i[grant_idx_o]) |=> $stable(grant_o));

  // R7
  back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && done_i && (elig != '0)) |=> grant_valid_o);

  // R8
  idle_when_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!grant_valid_o || done_i) && (elig == '0)) |=> !grant_valid_o);

  // R10
  drop_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && !en_i[grant_idx_o]) |=> !grant_o[$past(grant_idx_o)]);
endmodule

bind dma_ch_arbiter dma_ch_arbiter_chk #(.CH_N(CH_N)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .done_i        (done_i),
  .elig          (elig),
  .grant_o       (grant_o),
  .grant_idx_o   (grant_idx_o),
  .grant_valid_o (grant_valid_o)
);

// File: tb/dma_ch_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_ch_arbiter_tb_top;
  localparam int CH_N = 16;
  localparam int PW   = 4;
  localparam int IW   = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [CH_N-1:0] en_i = '0, src_ext_i = '0, wmark_sel_i = '0;
  logic [CH_N*PW-1:0] prio_i = '0;
  logic [CH_N-1:0] fifo_hungry_i = '0, fifo_wmark_i = '0, ext_req_i = '0;
  logic done_i = 1'b0;
  logic [CH_N-1:0] grant_o;
  logic [IW-1:0] grant_idx_o;
  logic grant_valid_o;

  int checks = 0, failures = 0;
  bit m_valid = 0;
  int m_idx = 0;

  always #5 clk_i = ~clk_i;

  dma_ch_arbiter dut_i (.*);

  function automatic bit req_of(int c);
    if (src_ext_i[c]) return ext_req_i[c];
    return wmark_sel_i[c] ? fifo_wmark_i[c] : fifo_hungry_i[c];
  endfunction

  function automatic int pick();
    int best = -1;
    for (int c = 0; c < CH_N; c++)
      if (en_i[c] && req_of(c))
        if (best < 0 || prio_i[c*PW +: PW] < prio_i[best*PW +: PW]) best = c;
    return best;
  endfunction

  task automatic check(string tag);
    logic [CH_N-1:0] eg;
    eg = m_valid ? (CH_N'(1) << m_idx) : '0;
    checks++;
    if (grant_o !== eg || grant_valid_o !== m_valid || (m_valid && grant_idx_o !== IW'(m_idx))) begin
      failures++;
      $display("FAIL %s: grant=%h idx=%0d valid=%b expected grant=%h idx=%0d valid=%b",
               tag, grant_o, grant_idx_o, grant_valid_o, eg, m_idx, m_valid);
    end
  endtask

  // one clock: model next state from inputs present at the edge, then compare
  task automatic tick(bit done, string tag);
    int w;
    done_i = done;
    if (!m_valid || done || !en_i[m_idx]) begin
      w = pick();
      m_valid = (w >= 0);
      m_idx = (w >= 0) ? w : 0;
    end
    @(posedge clk_i);
    #2;
    done_i = 1'b0;
    check(tag);
  endtask

  task automatic clear_all();
    en_i = '0; src_ext_i = '0; wmark_sel_i = '0; prio_i = '0;
    fifo_hungry_i = '0; fifo_wmark_i = '0; ext_req_i = '0;
  endtask

  task automatic set_prio(int c, int p);
    prio_i[c*PW +: PW] = PW'(p);
  endtask

  initial begin
    #2_000_000;
    checks++; failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5a_7c03));
    // R1: outputs cleared during reset even with requests present
    en_i = '1; fifo_hungry_i = '1;
    repeat (3) @(posedge clk_i);
    #2;
    checks++;
    if (grant_o !== '0 || grant_valid_o !== 1'b0 || grant_idx_o !== '0) begin
      failures++;
      $display("FAIL R1: grant=%h valid=%b idx=%0d expected 0/0/0", grant_o, grant_valid_o, grant_idx_o);
    end
    clear_all();
    @(negedge clk_i);
    rst_ni = 1'b1;
    #2;
    tick(0, "R8 idle after reset");

    // R2: source selection on channel 3
    en_i[3] = 1; src_ext_i[3] = 1; ext_req_i[3] = 1;
    tick(0, "R2 external request");
    ext_req_i[3] = 0; fifo_hungry_i[3] = 1;
    tick(1, "R2 external select ignores hungry");
    src_ext_i[3] = 0;
    tick(0, "R2 internal hungry");
    wmark_sel_i[3] = 1;
    tick(1, "R2 watermark select ignores hungry");
    fifo_wmark_i[3] = 1;
    tick(0, "R2 internal watermark");
    tick(1, "R2 reissue");
    clear_all();
    tick(1, "R8 no eligible");

    // R3: disabled requester is never granted
    fifo_hungry_i = '1; en_i = 16'hFFFE; set_prio(0, 0);
    for (int c = 1; c < CH_N; c++) set_prio(c, 9);
    tick(0, "R3 disabled top-priority channel skipped");
    tick(1, "R5 tie lowest index");

    // R4: smallest value wins
    set_prio(12, 2);
    tick(1, "R4 smallest priority");
    // R6: hold despite better request
    set_prio(7, 0);
    tick(0, "R6 hold on new priority");
    fifo_hungry_i[12] = 0;
    tick(0, "R6 hold after request drop");
    // R7: back-to-back handover
    tick(1, "R7 back-to-back");
    // R10: held channel disabled
    en_i[7] = 0;
    tick(0, "R10 release on disable");
    // R5: full tie
    for (int c = 0; c < CH_N; c++) set_prio(c, 15);
    en_i = '1; fifo_hungry_i = 16'h8421;
    tick(1, "R5 tie at lowest urgency");
    fifo_hungry_i = 16'h8000; set_prio(15, 15);
    tick(1, "R4 only high index");
    clear_all();
    tick(1, "R8 all cleared");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      en_i = CH_N'($urandom) | CH_N'($urandom);
      src_ext_i = CH_N'($urandom);
      wmark_sel_i = CH_N'($urandom);
      fifo_hungry_i = CH_N'($urandom) & CH_N'($urandom);
      fifo_wmark_i = CH_N'($urandom) & CH_N'($urandom);
      ext_req_i = CH_N'($urandom) & CH_N'($urandom);
      for (int c = 0; c < CH_N; c++) set_prio(c, $urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) en_i = '0;
      tick($urandom_range(0, 9) < 3, "R4 random arbitration");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule